// File: doc/BRIEF.md
# Four-Operation Integer ALU with Condition Flags

This block is a purely combinational integer unit of parameterised width (32 bits by default). A two-bit operation code selects one of four functions applied to the operands: sum, difference, bitwise conjunction or bitwise disjunction. The block always produces a result word and four condition flags: sign, zero, unsigned carry and signed overflow. It is meant to sit in an execute stage, and whatever surrounds it registers its outputs.

Subtraction needs no adder of its own. The low bit of the operation code inverts the second operand and also serves as the adder's carry-in, so the one adder that sums the operands also forms a + ~b + 1. The adder is a carry-lookahead design. Its columns are grouped into blocks of a parameterised size. Each block forms a group generate and a group propagate term, and those terms carry between blocks. A four-way selector steered by the operation code picks the result. The sign and zero flags are derived from that selected word. The carry and overflow flags are meaningful only for the two arithmetic operations and are held low for the logic operations.

There is no state machine, clock or reset inside the block. The outputs follow the inputs through gates alone.

Top module: `quad_alu`

## Requirements
- R1: With op_sel = 2'b00 the output res equals (opd_a + opd_b) modulo 2^W.
- R2: With op_sel = 2'b01 the output res equals (opd_a - opd_b) modulo 2^W.
- R3: With op_sel = 2'b10 the output res equals opd_a AND opd_b, bit by bit.
- R4: With op_sel = 2'b11 the output res equals opd_a OR opd_b, bit by bit.
- R5: For every operation, flag_neg equals bit W-1 of res.
- R6: For every operation, flag_zero is 1 exactly when all W bits of res are 0.
- R7: For an addition, flag_carry is the carry out of bit W-1 of the unsigned sum. For a subtraction, flag_carry is 1 exactly when opd_a >= opd_b as unsigned values, which means no borrow.
- R8: For an addition, flag_ovf is 1 exactly when both operands have the same sign bit and the sign bit of res differs from it. Examples: 0x7FFFFFFF + 1 and 0x80000000 + 0x80000000.
- R9: For a subtraction, flag_ovf is 1 exactly when the operands have different sign bits and the sign bit of res differs from that of opd_a. Examples: 0x80000000 - 1 and 0 - 0x80000000.
- R10: For op_sel[1] = 1 (AND, OR), flag_carry and flag_ovf are both 0 whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_a | input | W | First operand |
| opd_b | input | W | Second operand |
| op_sel | input | 2 | 00 add, 01 subtract, 10 AND, 11 OR |
| res | output | W | Selected result word |
| flag_neg | output | 1 | Sign bit of res |
| flag_zero | output | 1 | res is all zeros |
| flag_carry | output | 1 | Adder carry out, arithmetic operations only |
| flag_ovf | output | 1 | Signed overflow, arithmetic operations only |

## Verification
Carry and overflow can both be raised by a single operation in the same evaluation, and the bench provokes this on purpose. Adding 0x80000000 to itself must give a zero result with carry, overflow and zero all set together. Subtracting 1 from 0x80000000 must give carry (no borrow) and overflow on the non-zero result 0x7FFFFFFF. Each flag is compared separately against a bench model that uses wide signed arithmetic and an unsigned comparison, so an error in one flag cannot hide behind a correct value in the other. The same extreme operand pairs are also applied under the logic codes, where an adder that would have carried or overflowed must leave both flags low.

// File: rtl/qalu_pkg.sv
package qalu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } alu_op_e;

    // bit 1 of the code separates logic operations from arithmetic ones
    function automatic logic is_logic(input logic [1:0] code);
        return code[1];
    endfunction

endpackage

// File: rtl/qalu_cla.sv
module qalu_cla #(
    parameter int W   = 32,
    parameter int BLK = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NBLK = W / BLK;

    logic [W-1:0]  gen_col;
    logic [W-1:0]  prp_col;
    logic [NBLK:0] blk_c;

    assign gen_col = x & y;
    assign prp_col = x | y;
    assign blk_c[0] = cin;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        logic [BLK:0]   cc;
        logic           grp_g;
        logic           grp_p;
        logic [BLK-1:0] s_loc;

        // group terms, independent of the incoming carry
        always_comb begin
            grp_g = 1'b0;
            grp_p = 1'b1;
            for (int i = 0; i < BLK; i++) begin
                grp_g = gen_col[b*BLK+i] | (prp_col[b*BLK+i] & grp_g);
                grp_p = grp_p & prp_col[b*BLK+i];
            end
        end

        // local carries and sum bits inside the block
        always_comb begin
            cc[0] = blk_c[b];
            for (int i = 0; i < BLK; i++) begin
                cc[i+1]  = gen_col[b*BLK+i] | (prp_col[b*BLK+i] & cc[i]);
                s_loc[i] = x[b*BLK+i] ^ y[b*BLK+i] ^ cc[i];
            end
        end

        assign blk_c[b+1] = grp_g | (grp_p & blk_c[b]);
        assign sum[b*BLK +: BLK] = s_loc;
    end

    assign cout = blk_c[NBLK];

endmodule

// File: rtl/qalu_logic.sv
module qalu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] conj,
    output logic [W-1:0] disj
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign conj[i] = x[i] & y[i];
        assign disj[i] = x[i] | y[i];
    end
endmodule

// File: rtl/qalu_flags.sv
module qalu_flags #(
    parameter int W = 32
) (
    input  logic [W-1:0] word,
    input  logic [1:0]   code,
    input  logic         add_cout,
    input  logic         a_msb,
    input  logic         b_msb,
    input  logic         sum_msb,
    output logic         f_n,
    output logic         f_z,
    output logic         f_c,
    output logic         f_v
);
    import qalu_pkg::*;

    logic arith;
    logic sign_rule;

    assign arith = ~is_logic(code);
    assign f_n   = word[W-1];
    assign f_z   = ~|word;
    assign f_c   = arith & add_cout;

    // add: operands alike in sign; subtract: operands differ in sign
    assign sign_rule = ~(code[0] ^ a_msb ^ b_msb);
    assign f_v = arith & sign_rule & (a_msb ^ sum_msb);

endmodule

// File: rtl/quad_alu.sv
module quad_alu #(
    parameter int W   = 32,
    parameter int BLK = 4
) (
    input  logic [W-1:0] opd_a,
    input  logic [W-1:0] opd_b,
    input  logic [1:0]   op_sel,
    output logic [W-1:0] res,
    output logic         flag_neg,
    output logic         flag_zero,
    output logic         flag_carry,
    output logic         flag_ovf
);
    import qalu_pkg::*;

    logic [W-1:0] b_cond;
    logic [W-1:0] sum_w;
    logic         sum_co;
    logic [W-1:0] and_w;
    logic [W-1:0] or_w;
    alu_op_e      op_e;

    assign op_e   = alu_op_e'(op_sel);
    assign b_cond = opd_b ^ {W{op_sel[0]}};

    qalu_cla #(.W(W), .BLK(BLK)) u_add (
        .x    (opd_a),
        .y    (b_cond),
        .cin  (op_sel[0]),
        .sum  (sum_w),
        .cout (sum_co)
    );

    qalu_logic #(.W(W)) u_log (
        .x    (opd_a),
        .y    (opd_b),
        .conj (and_w),
        .disj (or_w)
    );

    always_comb begin
        unique case (op_e)
            OP_ADD:  res = sum_w;
            OP_SUB:  res = sum_w;
            OP_AND:  res = and_w;
            OP_OR:   res = or_w;
            default: res = sum_w;
        endcase
    end

    qalu_flags #(.W(W)) u_flg (
        .word     (res),
        .code     (op_sel),
        .add_cout (sum_co),
        .a_msb    (opd_a[W-1]),
        .b_msb    (opd_b[W-1]),
        .sum_msb  (sum_w[W-1]),
        .f_n      (flag_neg),
        .f_z      (flag_zero),
        .f_c      (flag_carry),
        .f_v      (flag_ovf)
    );

endmodule

// File: rtl/qalu_chk.sv
module qalu_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] opd_a,
    input logic [W-1:0] opd_b,
    input logic [1:0]   op_sel,
    input logic [W-1:0] res,
    input logic         flag_neg,
    input logic         flag_zero,
    input logic         flag_carry,
    input logic         flag_ovf
);
    logic [W:0] wide_add;
    assign wide_add = {1'b0, opd_a} + {1'b0, opd_b};

    always_comb begin
        a_r5_neg_msb: assert (flag_neg == res[W-1])
            else $error("R5 sign flag disagrees with result");
        a_r6_zero: assert (flag_zero == (res == '0))
            else $error("R6 zero flag disagrees with result");
        if (op_sel[1]) begin
            a_r10_logic_quiet: assert (!flag_carry && !flag_ovf)
                else $error("R10 carry/overflow raised by logic op");
        end
        if (op_sel == 2'b00) begin
            a_r1_add_sum: assert ({flag_carry, res} == wide_add)
                else $error("R1 sum/carry mismatch");
            a_r8_add_ovf: assert (flag_ovf == ((opd_a[W-1] == opd_b[W-1]) && (res[W-1] != opd_a[W-1])))
                else $error("R8 add overflow mismatch");
        end
        if (op_sel == 2'b01) begin
            a_r7_sub_carry: assert (flag_carry == (opd_a >= opd_b))
                else $error("R7 subtract carry mismatch");
            a_r9_sub_ovf: assert (flag_ovf == ((opd_a[W-1] != opd_b[W-1]) && (res[W-1] != opd_a[W-1])))
                else $error("R9 subtract overflow mismatch");
        end
        if (op_sel == 2'b10) begin
            a_r3_and: assert (res == (opd_a & opd_b))
                else $error("R3 AND mismatch");
        end
        if (op_sel == 2'b11) begin
            a_r4_or: assert (res == (opd_a | opd_b))
                else $error("R4 OR mismatch");
        end
    end
endmodule

bind quad_alu qalu_chk #(.W(W)) u_chk (
    .opd_a      (opd_a),
    .opd_b      (opd_b),
    .op_sel     (op_sel),
    .res        (res),
    .flag_neg   (flag_neg),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .flag_ovf   (flag_ovf)
);

// File: tb/sim_quad_alu.sv
module sim_quad_alu;
    localparam int W  = 32;
    localparam int VW = 2 + 3*W + 4;
    localparam int NV = 12;

    // {op, a, b, expected res, expected {N,Z,C,V}}
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'b00, 32'h00000005, 32'h00000007, 32'h0000000C, 4'b0000},
        {2'b00, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b1001},
        {2'b00, 32'h80000000, 32'h80000000, 32'h00000000, 4'b0111},
        {2'b00, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b0110},
        {2'b01, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 4'b0011},
        {2'b01, 32'h00000005, 32'h00000005, 32'h00000000, 4'b0110},
        {2'b01, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 4'b1000},
        {2'b01, 32'h00000000, 32'h80000000, 32'h80000000, 4'b1001},
        {2'b10, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 4'b1000},
        {2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'b1000},
        {2'b11, 32'h00000000, 32'h00000000, 32'h00000000, 4'b0100},
        {2'b11, 32'h0F0F0000, 32'h00000F0F, 32'h0F0F0F0F, 4'b0000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opd_a = '0;
    logic [W-1:0] opd_b = '0;
    logic [1:0]   op_sel = 2'b00;
    logic [W-1:0] res;
    logic         flag_neg, flag_zero, flag_carry, flag_ovf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    quad_alu #(.W(W), .BLK(4)) u0 (
        .opd_a      (opd_a),
        .opd_b      (opd_b),
        .op_sel     (op_sel),
        .res        (res),
        .flag_neg   (flag_neg),
        .flag_zero  (flag_zero),
        .flag_carry (flag_carry),
        .flag_ovf   (flag_ovf)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent model: {res, N, Z, C, V}
    function automatic logic [W+3:0] model(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r;
        logic c, v;
        longint sa, sb, st;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        c = 1'b0;
        v = 1'b0;
        case (op)
            2'b00: begin
                r  = a + b;
                c  = ({1'b0, a} + {1'b0, b}) > {1'b0, {W{1'b1}}};
                st = sa + sb;
                v  = (st > 64'sd2147483647) || (st < -64'sd2147483648);
            end
            2'b01: begin
                r  = a - b;
                c  = (a >= b);
                st = sa - sb;
                v  = (st > 64'sd2147483647) || (st < -64'sd2147483648);
            end
            2'b10:   r = a & b;
            default: r = a | b;
        endcase
        return {r, r[W-1], (r == '0), c, v};
    endfunction

    function automatic string res_tag(input logic [1:0] op);
        case (op)
            2'b00: return "R1 result";
            2'b01: return "R2 result";
            2'b10: return "R3 result";
            default: return "R4 result";
        endcase
    endfunction

    function automatic string c_tag(input logic [1:0] op);
        return op[1] ? "R10 carry" : "R7 carry";
    endfunction

    function automatic string v_tag(input logic [1:0] op);
        case (op)
            2'b00: return "R8 overflow";
            2'b01: return "R9 overflow";
            default: return "R10 overflow";
        endcase
    endfunction

    task automatic apply(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] er, input logic [3:0] ef);
        @(posedge clk);
        op_sel = op;
        opd_a  = a;
        opd_b  = b;
        @(negedge clk);
        chk(res_tag(op), res, er);
        chk("R5 sign", W'(flag_neg), W'(ef[3]));
        chk("R6 zero", W'(flag_zero), W'(ef[2]));
        chk(c_tag(op), W'(flag_carry), W'(ef[1]));
        chk(v_tag(op), W'(flag_ovf), W'(ef[0]));
    endtask

    task automatic apply_model(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W+3:0] m;
        m = model(op, a, b);
        apply(op, a, b, m[W+3:4], m[3:0]);
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] ext [5];
        ext = '{32'h00000000, 32'h00000001, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};

        repeat (3) @(posedge clk);
        rst = 1'b0;

        // quiescent state: zero operands, add code -> zero result, only Z set (R6)
        @(negedge clk);
        chk("R1 idle result", res, '0);
        chk("R6 idle zero", W'(flag_zero), W'(1'b1));
        chk("R7 idle carry", W'(flag_carry), W'(1'b0));

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            apply(v[VW-1:VW-2], v[VW-3:VW-2-W], v[VW-3-W:4+W], v[W+3:4], v[3:0]);
        end

        // extremes against each other under every code (R7 R8 R9 R10)
        for (int op = 0; op < 4; op++) begin
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 5; j++) begin
                    apply_model(2'(op), ext[i], ext[j]);
                end
            end
        end

        // random operands
        for (int k = 0; k < 400; k++) begin
            apply_model(2'(k % 4), $urandom, $urandom);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule